// File: doc/BRIEF.md
# Serial link word framer

The framer sits on the transmit side of a one-way serial link and turns user writes into 20-bit frames for a downstream serializer. A write carries a 32-bit data bus, a strobe, a control/data select and a test-word select. A width input chooses between 16-bit and 32-bit operation. A 16-bit data word becomes one frame. A 32-bit data word becomes two frames, and a flag output marks which half each frame carries. Data frames protect every nibble of the payload with an odd parity bit. Control frames use a different layout: a single parity bit over the 16 payload bits, and one bit that tells a test control word from a normal one.

After reset the framer emits fill frames for a fixed number of clock cycles, set by a parameter. This gives the receiver time to lock before any user frame arrives. While the fill interval runs, and while the second half of a 32-bit word is pending, the framer raises a full flag. A write presented against that flag is dropped, and a sticky overrun flag records the loss.

Top module: `serial_link_framer`

## Requirements
- R1: A data frame carries the 16-bit payload in bits 15..0. Bits 19..16 hold the odd parity of the nibbles, from bits 3..0 up to bits 15..12, so bit 16 covers the lowest nibble. Each nibble together with its parity bit has an odd number of ones.
- R2: In 32-bit mode (wide=1) a data write yields two frames on consecutive clocks. The first carries wr_data[31:16] with frame_flag=1. The second carries wr_data[15:0] with frame_flag=0.
- R3: A control frame has frame_ctrl=1. Its bit 17 is 1 for a normal control word (wr_test=0) and 0 for a test control word (wr_test=1). Its bit 16 is chosen so that bits 16..0 hold an odd number of ones.
- R4: In a control frame, bits 15..4 copy wr_data[15:4], while bits 3..0 and bits 19..18 are zero. A control word is always a single frame with frame_flag=0, in either width mode.
- R5: After reset is released, fill=1 and full=1 for exactly SYNC_CYCLES clock edges, and no frame is valid during that time. In fill and idle cycles frame_valid=0.
- R6: In 16-bit mode full stays 0 after the fill interval. In 32-bit mode full is 1 in the cycle after an accepted data write, while the lower half is being sent, and falls once that half has been sent.
- R7: A write while full=1 produces no frame and sets overrun. Overrun stays at 1 until reset, and reset clears it to 0.
- R8: An accepted write appears at the outputs right after the clock edge that samples it, at a rate of one frame per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide | input | 1 | 1 = 32-bit words, 0 = 16-bit words |
| wr_en | input | 1 | Write strobe |
| wr_ctrl | input | 1 | 1 = control word, 0 = data word |
| wr_test | input | 1 | For control words: 1 = test control word |
| wr_data | input | 32 | Write payload |
| full | output | 1 | Cannot accept a write this cycle |
| overrun | output | 1 | Sticky: a write was dropped |
| fill | output | 1 | Fill frames are being sent |
| frame | output | 20 | Frame to the serializer |
| frame_valid | output | 1 | frame holds a user frame |
| frame_ctrl | output | 1 | The frame is a control frame |
| frame_flag | output | 1 | The frame carries the upper half of a 32-bit word |

## Verification
The bench drives each write half a clock before the edge that samples it. The frame for that write is due just after that edge. In 32-bit mode the lower half follows one edge later, and full rises for exactly that one cycle. A driver task pushes the expected frames, in order, into a queue. A monitor that samples 2 ns after every rising edge pops one entry for each valid frame. Any frame that arrives when the queue is empty, or that does not match the head of the queue, is reported. The fill interval is checked at its last high edge and at its first low edge. The full and overrun flags are checked in the sample right after the edge that should change them.

// File: rtl/serial_link_framer.sv
module serial_link_framer #(
  parameter int SYNC_CYCLES = 125000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wide,
  input  logic        wr_en,
  input  logic        wr_ctrl,
  input  logic        wr_test,
  input  logic [31:0] wr_data,
  output logic        full,
  output logic        overrun,
  output logic        fill,
  output logic [19:0] frame,
  output logic        frame_valid,
  output logic        frame_ctrl,
  output logic        frame_flag
);
  localparam int CW = $clog2(SYNC_CYCLES + 2);
  localparam logic [CW-1:0] SYNC_END = CW'(SYNC_CYCLES);

  logic [CW-1:0] sync_cnt;
  logic          pend;
  logic [15:0]   hold;
  logic          accept;

  function automatic logic [19:0] data_frame(input logic [15:0] d);
    return {~^d[15:12], ~^d[11:8], ~^d[7:4], ~^d[3:0], d};
  endfunction

  assign fill   = (sync_cnt != SYNC_END);
  assign full   = fill | pend;
  assign accept = wr_en & ~full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_cnt    <= '0;
      pend        <= 1'b0;
      hold        <= '0;
      overrun     <= 1'b0;
      frame       <= '0;
      frame_valid <= 1'b0;
      frame_ctrl  <= 1'b0;
      frame_flag  <= 1'b0;
    end else begin
      if (fill) sync_cnt <= sync_cnt + 1'b1;
      if (wr_en && full) overrun <= 1'b1;
      frame       <= '0;
      frame_valid <= 1'b0;
      frame_ctrl  <= 1'b0;
      frame_flag  <= 1'b0;
      if (pend) begin
        frame       <= data_frame(hold);
        frame_valid <= 1'b1;
        pend        <= 1'b0;
      end else if (accept) begin
        frame_valid <= 1'b1;
        if (wr_ctrl) begin
          frame      <= {2'b00, ~wr_test, ~^wr_data[15:4], wr_data[15:4], 4'h0};
          frame_ctrl <= 1'b1;
        end else if (wide) begin
          frame      <= data_frame(wr_data[31:16]);
          frame_flag <= 1'b1;
          pend       <= 1'b1;
          hold       <= wr_data[15:0];
        end else begin
          frame      <= data_frame(wr_data[15:0]);
        end
      end
    end
  end

  a_r1_nibble_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !frame_ctrl) |->
      (^{frame[16], frame[3:0]}) && (^{frame[17], frame[7:4]}) &&
      (^{frame[18], frame[11:8]}) && (^{frame[19], frame[15:12]}));

  a_r2_lower_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && frame_flag) |=> (frame_valid && !frame_flag && !frame_ctrl));

  a_r3_ctrl_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && frame_ctrl) |-> (^frame[16:0]));

  a_r4_ctrl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && frame_ctrl) |-> (frame[3:0] == 4'h0 && frame[19:18] == 2'b00 && !frame_flag));

  a_r5_no_data_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    fill |-> !frame_valid);

  a_r6_narrow_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!full && wr_en && !wide) |=> !full);

  a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full) |=> overrun);

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
endmodule

// File: tb/tb_serial_link_framer.sv
module tb_serial_link_framer;
  localparam int N = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wide = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_ctrl = 1'b0;
  logic        wr_test = 1'b0;
  logic [31:0] wr_data = '0;
  logic        full, overrun, fill, frame_valid, frame_ctrl, frame_flag;
  logic [19:0] frame;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [21:0] expq[$];

  serial_link_framer #(.SYNC_CYCLES(N)) dut (
    .clk(clk), .rst_n(rst_n), .wide(wide), .wr_en(wr_en), .wr_ctrl(wr_ctrl),
    .wr_test(wr_test), .wr_data(wr_data), .full(full), .overrun(overrun),
    .fill(fill), .frame(frame), .frame_valid(frame_valid),
    .frame_ctrl(frame_ctrl), .frame_flag(frame_flag));

  always #4 clk = ~clk;

  function automatic logic odd_bit(input logic [15:0] v, input int n);
    int ones = 0;
    for (int i = 0; i < n; i++) ones += v[i];
    return (ones % 2 == 0);
  endfunction

  function automatic logic [19:0] exp_data(input logic [15:0] d);
    logic [19:0] f;
    f[15:0] = d;
    for (int k = 0; k < 4; k++) f[16+k] = odd_bit(16'(d >> (4*k)), 4);
    return f;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // monitor
  always @(posedge clk) begin
    #2;
    if (rst_n && frame_valid) begin
      if (expq.size() == 0) check("R7 unexpected frame", {10'h0, frame_ctrl, frame_flag, frame}, 32'hFFFFFFFF);
      else check("R8 frame", {10'h0, frame_ctrl, frame_flag, frame}, {10'h0, expq.pop_front()});
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_en = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R7 reset overrun", overrun, 0);
    check("R5 reset frame_valid", frame_valid, 0);
    rst_n = 1'b1;
  endtask

  task automatic wr_word(input logic w, input logic c, input logic t, input logic [31:0] d);
    @(negedge clk);
    wide = w; wr_ctrl = c; wr_test = t; wr_data = d; wr_en = 1'b1;
    if (c) expq.push_back({1'b1, 1'b0, 2'b00, ~t, odd_bit({d[15:4], 4'h0}, 16), d[15:4], 4'h0});
    else if (w) begin
      expq.push_back({1'b0, 1'b1, exp_data(d[31:16])});
      expq.push_back({1'b0, 1'b0, exp_data(d[15:0])});
    end else expq.push_back({1'b0, 1'b0, exp_data(d[15:0])});
    @(posedge clk); #2;
    check(w && !c ? "R6 full after wide write" : "R6 full after single frame", full, w && !c);
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    do_reset();
    repeat (N-1) @(posedge clk);
    #2;
    check("R5 fill high at edge N-1", fill, 1);
    check("R5 full during fill", full, 1);
    @(posedge clk); #2;
    check("R5 fill low at edge N", fill, 0);
    check("R6 full low after fill", full, 0);

    wr_word(1'b0, 1'b0, 1'b0, 32'h0000_1234);   // R1
    wr_word(1'b0, 1'b0, 1'b0, 32'h0000_FFFF);   // R1 all ones
    wr_word(1'b0, 1'b0, 1'b0, 32'h0000_0000);   // R1 all zeros
    wr_word(1'b1, 1'b0, 1'b0, 32'hDEAD_BEEF);   // R2
    wr_word(1'b1, 1'b0, 1'b0, 32'h0001_8000);   // R2
    wr_word(1'b0, 1'b1, 1'b0, 32'h0000_ABCF);   // R3 normal, R4 low nibble cleared
    wr_word(1'b0, 1'b1, 1'b1, 32'h0000_7010);   // R3 test
    wr_word(1'b1, 1'b1, 1'b0, 32'hFFFF_0F0F);   // R4 control in wide mode
    @(posedge clk); #2;
    check("R6 full idle", full, 0);
    check("R7 no overrun yet", overrun, 0);

    // R7: back-to-back wide writes, second is dropped
    @(negedge clk);
    wide = 1'b1; wr_ctrl = 1'b0; wr_data = 32'h1357_2468; wr_en = 1'b1;
    expq.push_back({1'b0, 1'b1, exp_data(16'h1357)});
    expq.push_back({1'b0, 1'b0, exp_data(16'h2468)});
    @(negedge clk);
    wr_data = 32'hAAAA_5555;
    @(posedge clk); #2;
    check("R7 overrun set", overrun, 1);
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R7 overrun sticky", overrun, 1);
    check("R2 queue drained", expq.size(), 0);

    // R7 during fill: write dropped, no frame
    do_reset();
    @(negedge clk);
    wide = 1'b0; wr_data = 32'h0000_4321; wr_en = 1'b1;
    @(posedge clk); #2;
    check("R7 overrun during fill", overrun, 1);
    check("R5 no frame during fill", frame_valid, 0);
    @(negedge clk); wr_en = 1'b0;
    do_reset();
    repeat (N+2) @(posedge clk);
    #2;
    check("R7 overrun cleared", overrun, 0);
    check("R8 queue empty at end", expq.size(), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule